// File: doc/BRIEF.md
# Serial Clock-Enable Register Slave

This block lets a host on a two-wire serial bus switch individual fanout clock outputs on and off. It watches the bus clock and data lines and answers its own write transactions. Each accepted data byte lands in a small bank of byte-wide enable registers. Every implemented register bit gates a reference clock onto one output of a vector.

The bus lines are brought into the system clock domain by a two-flop synchroniser. START, STOP and clock edges are taken from the synchronised copies. The system clock must run at least eight times faster than the bus clock. The slave answers a base 7-bit address with one address bit treated as don't-care, so two addresses reach it.

The first byte after the address is a command byte. With bit 7 clear it selects a register for plain writes. With bit 7 set it starts a counted block write. Each output is gated by an enable that changes only while the reference clock is low, so no output ever emits a shortened pulse.

Top module: `fanout_gate_slave`

## Requirements
- R1: After reset every enable register is zero and every clk_o bit stays low until a data byte has been written.
- R2: The address byte {addr[6:0], rw} is matched against DEV_ADDR = 7'h69 with bit 2 ignored, so bus bytes 8'hD2 and 8'hDA (write) are both accepted.
- R3: An address byte that does not match is not acknowledged, and all further bytes up to the next START are ignored and leave the outputs unchanged.
- R4: A START (SDA falling while SCL high) always restarts address reception, including a repeated START inside a transaction. A STOP (SDA rising while SCL high) returns the slave to idle, so later bytes sent without a START are not acknowledged.
- R5: For each accepted byte the slave pulls SDA low (sda_oe_o = 1) from the SCL fall after the eighth bit until the SCL fall after the ninth clock. It changes sda_oe_o only while SCL is low.
- R6: A command byte with bit 7 = 0 loads the register pointer with bits [6:0]. A following data byte is written there: a 1 in bit b of register r enables clk_o[8*r+b], and a 0 disables it.
- R7: The pointer advances after every acknowledged data byte, so further bytes of the same transaction fill the following registers.
- R8: A command byte with bit 7 = 1 starts a block write at register bits [6:0] (0 by default). The next byte is a count, and up to that many data bytes are then stored in consecutive registers. Surplus bytes are acknowledged and discarded.
- R9: Register bits with no output (8*r+b >= N_OUT) ignore writes, so writing 8'hFF to register 1 enables only clk_o[9:8] and leaves clk_o[7:0] alone.
- R10: Data bytes addressed at or beyond register N_REGS are acknowledged and discarded.
- R11: An address byte that matches but has rw = 1 is not acknowledged.
- R12: clk_o is low whenever ref_clk_i is low, and every high pulse of clk_o lasts exactly one full high phase of ref_clk_i, even while its enable is toggled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock that is fanned out |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| clk_o | output | N_OUT | Gated copies of ref_clk_i |

## Verification
On every cycle the assertions check three things. The acknowledge drive must rise and fall only while SCL is low. No register write may target a pointer past the bank. The outputs must stay silent from reset until the first stored byte. Address decoding with the don't-care bit, refusal of reads and foreign addresses, and pointer auto-increment can only be shown by the bench's transactions. So can block counts with surplus bytes, repeated START and STOP handling, and the masking of reserved bits, all observed on clk_o. Glitch-free gating is checked by timing every output pulse against the reference half period.

// File: rtl/fgs_pkg.sv
package fgs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 7;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/fgs_sync_edge.sv
module fgs_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic              scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_p  <= scl_sr[STAGES-1];
      sda_p  <= sda_sr[STAGES-1];
    end
  end

  assign scl_o      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  // data line moving while clock held high marks a bus condition
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
endmodule

// File: rtl/fgs_rx.sv
module fgs_rx
  import fgs_pkg::*;
#(
  parameter int unsigned N_REGS   = 2,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter logic [6:0]  DC_MASK  = 7'b000_0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = '1;

  phase_e             phase_q;
  logic [3:0]         bit_cnt_q;
  logic [BYTE_W-1:0]  shreg_q;
  logic               ack_slot_q;
  logic               sda_oe_q;
  logic [PTR_W-1:0]   ptr_q;
  logic               blk_q;
  logic [BYTE_W-1:0]  cnt_q;
  logic               wr_en_q;
  logic [PTR_W-1:0]   wr_addr_q;
  logic [BYTE_W-1:0]  wr_data_q;

  logic byte_done, addr_hit, in_window, store;

  assign byte_done = (bit_cnt_q == 4'd8);
  assign addr_hit  = ((shreg_q[7:1] & ~DC_MASK) == (DEV_ADDR & ~DC_MASK)) && !shreg_q[0];
  assign in_window = !blk_q || (cnt_q != '0);
  assign store     = in_window && (ptr_q < PTR_W'(N_REGS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      ack_slot_q <= 1'b0;
      sda_oe_q   <= 1'b0;
      ptr_q      <= '0;
      blk_q      <= 1'b0;
      cnt_q      <= '0;
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        phase_q    <= PH_ADDR;
        bit_cnt_q  <= '0;
        ack_slot_q <= 1'b0;
        sda_oe_q   <= 1'b0;
      end else if (stop_i) begin
        phase_q    <= PH_IDLE;
        ack_slot_q <= 1'b0;
        sda_oe_q   <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (ack_slot_q) begin
          if (scl_fall_i) begin
            ack_slot_q <= 1'b0;
            sda_oe_q   <= 1'b0;
          end
        end else if (scl_rise_i && !byte_done) begin
          shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end else if (scl_fall_i && byte_done) begin
          bit_cnt_q <= '0;
          unique case (phase_q)
            PH_ADDR: begin
              if (addr_hit) begin
                ack_slot_q <= 1'b1;
                sda_oe_q   <= 1'b1;
                phase_q    <= PH_CMD;
              end else begin
                phase_q <= PH_IDLE;
              end
            end
            PH_CMD: begin
              ack_slot_q <= 1'b1;
              sda_oe_q   <= 1'b1;
              blk_q      <= shreg_q[7];
              ptr_q      <= shreg_q[PTR_W-1:0];
              phase_q    <= shreg_q[7] ? PH_CNT : PH_DATA;
            end
            PH_CNT: begin
              ack_slot_q <= 1'b1;
              sda_oe_q   <= 1'b1;
              cnt_q      <= shreg_q;
              phase_q    <= PH_DATA;
            end
            PH_DATA: begin
              ack_slot_q <= 1'b1;
              sda_oe_q   <= 1'b1;
              if (store) begin
                wr_en_q   <= 1'b1;
                wr_addr_q <= ptr_q;
                wr_data_q <= shreg_q;
              end
              if (in_window && ptr_q != PTR_LAST) ptr_q <= ptr_q + 1'b1;
              if (blk_q && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            end
            default: phase_q <= PH_IDLE;
          endcase
        end
      end
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
endmodule

// File: rtl/fgs_regbank.sv
module fgs_regbank
  import fgs_pkg::*;
#(
  parameter int unsigned N_REGS = 2,
  parameter int unsigned N_OUT  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [N_OUT-1:0]  en_o
);
  localparam int unsigned TOT = N_REGS * BYTE_W;

  logic [TOT-1:0] flat;

  function automatic logic [BYTE_W-1:0] live_bits(int unsigned r);
    logic [BYTE_W-1:0] m;
    for (int unsigned b = 0; b < BYTE_W; b++) m[b] = ((r * BYTE_W + b) < N_OUT);
    return m;
  endfunction

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    localparam logic [BYTE_W-1:0] MASK = live_bits(r);
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= '0;
      else if (wr_en_i && wr_addr_i == PTR_W'(r))    q <= wr_data_i & MASK;
    end
    assign flat[r*BYTE_W +: BYTE_W] = q;
  end

  assign en_o = flat[N_OUT-1:0];

  if (TOT > N_OUT) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^flat[TOT-1:N_OUT];
  end
endmodule

// File: rtl/fgs_clk_gate.sv
module fgs_clk_gate #(
  parameter int unsigned N_OUT  = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic [N_OUT-1:0] en_i,
  output logic [N_OUT-1:0] clk_o
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    logic [STAGES-1:0] en_sr;
    // enable moves only on the falling edge, so gating never clips a high phase
    always_ff @(negedge ref_clk_i or negedge rst_ni) begin
      if (!rst_ni) en_sr <= '0;
      else         en_sr <= {en_sr[STAGES-2:0], en_i[i]};
    end
    assign clk_o[i] = ref_clk_i & en_sr[STAGES-1];
  end
endmodule

// File: rtl/fanout_gate_slave.sv
module fanout_gate_slave
  import fgs_pkg::*;
#(
  parameter int unsigned N_REGS   = 2,
  parameter int unsigned N_OUT    = 10,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter logic [6:0]  DC_MASK  = 7'b000_0100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic [N_OUT-1:0] clk_o
);
  logic              scl_s, sda_s, start_p, stop_p, scl_rise, scl_fall;
  logic              reg_wr;
  logic [PTR_W-1:0]  reg_addr;
  logic [BYTE_W-1:0] reg_data;
  logic [N_OUT-1:0]  en_vec;
  logic              unused_scl;

  assign unused_scl = scl_s;

  fgs_sync_edge #(.STAGES(2)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .start_o    (start_p),
    .stop_o     (stop_p),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  fgs_rx #(.N_REGS(N_REGS), .DEV_ADDR(DEV_ADDR), .DC_MASK(DC_MASK)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .start_i    (start_p),
    .stop_i     (stop_p),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (reg_wr),
    .wr_addr_o  (reg_addr),
    .wr_data_o  (reg_data)
  );

  fgs_regbank #(.N_REGS(N_REGS), .N_OUT(N_OUT)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (reg_wr),
    .wr_addr_i (reg_addr),
    .wr_data_i (reg_data),
    .en_o      (en_vec)
  );

  fgs_clk_gate #(.N_OUT(N_OUT), .STAGES(2)) u_gate (
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_vec),
    .clk_o     (clk_o)
  );
endmodule

// File: rtl/fanout_gate_slave_chk.sv
module fanout_gate_slave_chk #(
  parameter int unsigned N_REGS = 2,
  parameter int unsigned N_OUT  = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic [N_OUT-1:0] clk_o,
  input logic             wr_en_i,
  input logic [6:0]       wr_addr_i
);
  logic wr_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wr_seen_q <= 1'b0;
    else if (wr_en_i) wr_seen_q <= 1'b1;
  end

  assert_outputs_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_seen_q |-> (clk_o == '0));

  assert_ack_rise_scl_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);

  assert_ack_fall_scl_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_i);

  assert_no_write_past_bank_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_addr_i < 7'(N_REGS)));
endmodule

bind fanout_gate_slave fanout_gate_slave_chk #(.N_REGS(N_REGS), .N_OUT(N_OUT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .clk_o     (clk_o),
  .wr_en_i   (reg_wr),
  .wr_addr_i (reg_addr)
);

// File: tb/fanout_gate_slave_bench.sv
`timescale 1ns/1ps
module fanout_gate_slave_bench;
  localparam int N_OUT = 10;
  localparam real QTR  = 50.0;   // quarter SCL period = 10 system clocks
  localparam real RHALF = 7.0;   // reference clock half period

  logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda_low = 1'b0;
  logic sda_oe;
  logic [N_OUT-1:0] clk_o;
  wire  sda_line = ~(m_sda_low | sda_oe);

  int n_chk = 0, n_fail = 0, glitches = 0, pulses = 0;
  bit done = 1'b0;
  real t_rise = 0.0;

  always #2.5 clk = ~clk;
  always #(RHALF) ref_clk = ~ref_clk;

  fanout_gate_slave u_fanout_gate_slave (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk),
    .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe), .clk_o(clk_o)
  );

  // R12: pulse width monitor on output 0
  always @(posedge clk_o[0]) t_rise = $realtime;
  always @(negedge clk_o[0]) begin
    if (rst_n) begin
      pulses++;
      if (($realtime - t_rise) > RHALF + 0.01 || ($realtime - t_rise) < RHALF - 0.01) glitches++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; #(QTR);
    m_scl = 1'b1;     #(QTR);
    m_sda_low = 1'b1; #(QTR);
    m_scl = 1'b0;     #(QTR);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; #(QTR);
    m_scl = 1'b1;     #(QTR);
    m_sda_low = 1'b0; #(QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; #(QTR);
      m_scl = 1'b1;      #(2*QTR);
      m_scl = 1'b0;      #(QTR);
    end
    m_sda_low = 1'b0; #(QTR);
    m_scl = 1'b1;     #(QTR);
    acked = (sda_line == 1'b0);
    #(QTR);
    m_scl = 1'b0;     #(QTR);
    chk(sda_oe == 1'b0, "R5 release", 32'(sda_oe), 0);
  endtask

  task automatic xfer(input logic [7:0] b, input bit exp_ack, input string req);
    bit a;
    send_byte(b, a);
    chk(a == exp_ack, req, 32'(a), 32'(exp_ack));
  endtask

  task automatic check_en(input logic [N_OUT-1:0] exp, input string req);
    logic [N_OUT-1:0] seen = '0;
    bit low_bad = 1'b0;
    repeat (4) @(posedge ref_clk);
    repeat (4) begin
      @(posedge ref_clk); #(RHALF/2);
      seen |= clk_o;
      @(negedge ref_clk); #(RHALF/2);
      if (clk_o != '0) low_bad = 1'b1;
    end
    chk(seen == exp, req, 32'(seen), 32'(exp));
    chk(!low_bad, "R12 low phase", 32'(low_bad), 0);
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // {dev[7:0], cmd[7:0], data[7:0], exp_en[9:0], ack}
  localparam int NV = 8;
  localparam logic [34:0] VEC [NV] = '{
    {8'hD2, 8'h00, 8'hA5, 10'h0A5, 1'b1},  // R6 byte write reg0
    {8'hDA, 8'h01, 8'h03, 10'h3A5, 1'b1},  // R2 alternate address
    {8'hD2, 8'h00, 8'h0F, 10'h30F, 1'b1},  // R6 clear bits
    {8'hDA, 8'h01, 8'hFE, 10'h20F, 1'b1},  // R9 reserved bits
    {8'hD2, 8'h05, 8'hFF, 10'h20F, 1'b1},  // R10 past the bank
    {8'hD3, 8'h00, 8'h00, 10'h20F, 1'b0},  // R11 read not acked
    {8'hD0, 8'h00, 8'h00, 10'h20F, 1'b0},  // R3 foreign address
    {8'hD2, 8'h00, 8'h00, 10'h200, 1'b1}   // R6 all off
  };

  initial begin
    #(1000000.0);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_test();
  end

  initial begin
    repeat (10) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (10) @(posedge clk);

    check_en('0, "R1 reset");

    for (int v = 0; v < NV; v++) begin
      logic [34:0] e = VEC[v];
      bus_start();
      xfer(e[34:27], e[0], "R2/R3/R11 addr ack");
      xfer(e[26:19], e[0], "R5 cmd ack");
      xfer(e[18:11], e[0], "R5 data ack");
      bus_stop();
      check_en(e[10:1], "R6/R9/R10 table");
    end

    // R7 auto-increment, third byte beyond the bank
    bus_start();
    xfer(8'hD2, 1'b1, "R7 addr");
    xfer(8'h00, 1'b1, "R7 cmd");
    xfer(8'h11, 1'b1, "R7 d0");
    xfer(8'h02, 1'b1, "R7 d1");
    xfer(8'h55, 1'b1, "R10 d2 acked");
    bus_stop();
    check_en(10'h211, "R7 auto-increment");

    // R8 block write count 1, surplus byte discarded
    bus_start();
    xfer(8'hD2, 1'b1, "R8 addr");
    xfer(8'h80, 1'b1, "R8 cmd");
    xfer(8'h01, 1'b1, "R8 count");
    xfer(8'h44, 1'b1, "R8 d0");
    xfer(8'h03, 1'b1, "R8 surplus acked");
    bus_stop();
    check_en(10'h244, "R8 block default start");

    // R8 block starting at register 1
    bus_start();
    xfer(8'hD2, 1'b1, "R8 addr");
    xfer(8'h81, 1'b1, "R8 cmd");
    xfer(8'h01, 1'b1, "R8 count");
    xfer(8'h01, 1'b1, "R8 d0");
    bus_stop();
    check_en(10'h144, "R8 block start reg1");

    // R8 count zero stores nothing
    bus_start();
    xfer(8'hD2, 1'b1, "R8 addr");
    xfer(8'h80, 1'b1, "R8 cmd");
    xfer(8'h00, 1'b1, "R8 count0");
    xfer(8'hFF, 1'b1, "R8 surplus acked");
    bus_stop();
    check_en(10'h144, "R8 count zero");

    // R4 repeated START restarts address reception
    bus_start();
    xfer(8'hD2, 1'b1, "R4 addr");
    xfer(8'h00, 1'b1, "R4 cmd");
    bus_start();
    xfer(8'hD0, 1'b0, "R4 foreign after rstart");
    xfer(8'hFF, 1'b0, "R3 ignored byte");
    bus_start();
    xfer(8'hD2, 1'b1, "R4 addr again");
    xfer(8'h01, 1'b1, "R4 cmd");
    xfer(8'h00, 1'b1, "R4 data");
    bus_stop();
    check_en(10'h044, "R4 repeated start");

    // R4 STOP returns to idle
    bus_start();
    xfer(8'hD2, 1'b1, "R4 addr");
    bus_stop();
    m_scl = 1'b0; #(QTR);
    xfer(8'h00, 1'b0, "R4 no start byte");
    xfer(8'h00, 1'b0, "R4 no start byte");
    m_sda_low = 1'b0; #(QTR);
    m_scl = 1'b1; #(QTR);
    check_en(10'h044, "R4 stop idle");

    // R12 toggle output 0 enable several times
    for (int k = 0; k < 4; k++) begin
      bus_start();
      xfer(8'hD2, 1'b1, "R12 addr");
      xfer(8'h00, 1'b1, "R12 cmd");
      xfer((k % 2 == 0) ? 8'h45 : 8'h44, 1'b1, "R12 data");
      bus_stop();
      check_en((k % 2 == 0) ? 10'h045 : 10'h044, "R12 toggle");
    end
    chk(glitches == 0, "R12 pulse width", 32'(glitches), 0);
    chk(pulses > 0, "R12 pulses seen", 32'(pulses), 1);

    done = 1'b1;
    finish_test();
  end
endmodule